// File: doc/BRIEF.md
# Programmable Horizontal and Vertical Sync Output Generator

This block regenerates a pair of sync outputs from an incoming timing reference. Two counters keep the raster position. A pixel counter restarts a programmable number of clocks after each rising edge of the horizontal input. A line counter clears a programmable number of clocks after each rising edge of the vertical input. The horizontal output begins at a chosen pixel and lasts a chosen number of clocks. The vertical output begins at a chosen line and lasts a chosen number of lines. A second start/length pair for the vertical output applies while the field flag marks the second field. Each output has its own polarity.

The block also measures its inputs. It reports how many clocks the horizontal input stayed high, and how many horizontal rising edges occurred while the vertical input was high. Both values are latched when the measured input falls, and both saturate. All inputs pass through two-flop synchronizers. Configuration is static and is changed only while no frame is in flight.

Top module: `sync_out_gen`

## Requirements
- R1: Rising edges are detected on the synchronized horizontal input. If that input is first sampled high at clock edge 0, the pixel counter reads 0 after edge 2+cfgHsInDly and then counts up by one per clock. A delay of 0 is allowed.
- R2: hsOut is active after edges 3+cfgHsInDly+cfgHDly through 2+cfgHsInDly+cfgHDly+cfgHLen, counted from that same edge 0, and is inactive just before and just after that window.
- R3: The line counter clears cfgVsInDly clocks after a synchronized vertical rising edge (edge 2+cfgVsInDly), and advances by one at every pixel-counter restart. When the clear and a restart fall on the same edge, the clear wins and the line reads 0.
- R4: At each pixel-counter restart the vertical output is re-evaluated, with the change visible after edge 3+cfgHsInDly. vsOut is active on lines cfgVDly through cfgVDly+cfgVLen-1.
- R5: While the synchronized field flag is 1, the second-field pair cfgVDly2/cfgVLen2 replaces cfgVDly/cfgVLen.
- R6: A polarity bit of 1 makes the matching output active high, and 0 makes it active low. After reset both outputs sit at their inactive level and both measurements read 0.
- R7: A length of 0 keeps the matching output inactive for the whole line or frame.
- R8: hsHighClks is loaded, when the synchronized horizontal input falls, with the number of clocks it was high.
- R9: vsHighLines is loaded, when the synchronized vertical input falls, with the number of horizontal rising edges seen while it was high.
- R10: Both measurements saturate at 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hsIn | input | 1 | Horizontal timing reference |
| vsIn | input | 1 | Vertical timing reference |
| fieldIn | input | 1 | 1 marks the second field |
| cfgHsInDly | input | 13 | Clocks from horizontal input edge to pixel-counter restart |
| cfgVsInDly | input | 13 | Clocks from vertical input edge to line-counter clear |
| cfgHDly | input | 13 | Pixel at which hsOut begins |
| cfgHLen | input | 10 | hsOut width in clocks |
| cfgVDly | input | 11 | First line of vsOut, first field |
| cfgVLen | input | 11 | vsOut length in lines, first field |
| cfgVDly2 | input | 11 | First line of vsOut, second field |
| cfgVLen2 | input | 11 | vsOut length in lines, second field |
| cfgHPol | input | 1 | hsOut polarity, 1 = active high |
| cfgVPol | input | 1 | vsOut polarity, 1 = active high |
| hsOut | output | 1 | Regenerated horizontal sync |
| vsOut | output | 1 | Regenerated vertical sync |
| hsHighClks | output | 16 | Last high time of the horizontal input, in clocks |
| vsHighLines | output | 16 | Last high time of the vertical input, in horizontal edges |

## Verification
Two situations are hard to reach from the ports. The first is saturation of the horizontal high-time counter. The stimulus holds the horizontal input high for more than 65,535 clocks in one stretch, then checks that the latched value is 16'hFFFF. The second is the clear-versus-advance precedence of the line counter, which only shows when both input delays line up exactly. The bench gives the vertical input the same delay as the horizontal one and raises it on the same clock as a horizontal edge. It then checks that the line starting there counts as line 0, through the line on which vsOut begins.

// File: rtl/syncgen_pkg.sv
package syncgen_pkg;
  // Strobes and levels handed from control to datapath each clock.
  typedef struct packed {
    logic pixRst;   // delayed horizontal edge: restart pixel count
    logic lineRst;  // delayed vertical edge: clear line count
    logic hsLvl;    // synchronized horizontal level
    logic hsRise;   // synchronized horizontal rising edge
    logic hsFall;   // synchronized horizontal falling edge
    logic vsLvl;    // synchronized vertical level
    logic vsFall;   // synchronized vertical falling edge
    logic field2;   // synchronized second-field flag
  } syncStrb_t;
endpackage

// File: rtl/sync_edge_delay.sv
module sync_edge_delay #(
  parameter int DLY_W = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rise,
  input  logic [DLY_W-1:0] dly,
  output logic             strobe
);
  logic [DLY_W-1:0] cnt;
  logic             pend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (rise) begin
      pend <= (dly != '0);
      cnt  <= dly;
    end else if (pend) begin
      if (cnt == DLY_W'(1)) pend <= 1'b0;
      else                  cnt  <= cnt - DLY_W'(1);
    end
  end

  assign strobe = (rise && dly == '0) || (!rise && pend && cnt == DLY_W'(1));

  // R1: a pending delay never outlives its own count
  a_r1_pend_counts_down: assert property (@(posedge clk) disable iff (!rstN)
    (pend && !rise && cnt != DLY_W'(1)) |=> (pend && cnt == $past(cnt) - DLY_W'(1)));
endmodule

// File: rtl/sync_ctrl.sv
module sync_ctrl
  import syncgen_pkg::*;
#(
  parameter int DLY_W = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hsIn,
  input  logic             vsIn,
  input  logic             fieldIn,
  input  logic [DLY_W-1:0] cfgHsInDly,
  input  logic [DLY_W-1:0] cfgVsInDly,
  output syncStrb_t        strb
);
  localparam int N_IN = 3;  // bit 0 horizontal, 1 vertical, 2 field

  logic [N_IN-1:0] rawIn, stg1, stg2, prev;
  logic            hsRise, vsRise, pixStrobe, lineStrobe;

  assign rawIn = {fieldIn, vsIn, hsIn};

  for (genvar i = 0; i < N_IN; i++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stg1[i] <= 1'b0;
        stg2[i] <= 1'b0;
        prev[i] <= 1'b0;
      end else begin
        stg1[i] <= rawIn[i];
        stg2[i] <= stg1[i];
        prev[i] <= stg2[i];
      end
    end
  end

  assign hsRise = stg2[0] & ~prev[0];
  assign vsRise = stg2[1] & ~prev[1];

  sync_edge_delay #(.DLY_W(DLY_W)) uHDelay (
    .clk(clk), .rstN(rstN), .rise(hsRise), .dly(cfgHsInDly), .strobe(pixStrobe));
  sync_edge_delay #(.DLY_W(DLY_W)) uVDelay (
    .clk(clk), .rstN(rstN), .rise(vsRise), .dly(cfgVsInDly), .strobe(lineStrobe));

  always_comb begin
    strb.pixRst  = pixStrobe;
    strb.lineRst = lineStrobe;
    strb.hsLvl   = stg2[0];
    strb.hsRise  = hsRise;
    strb.hsFall  = ~stg2[0] & prev[0];
    strb.vsLvl   = stg2[1];
    strb.vsFall  = ~stg2[1] & prev[1];
    strb.field2  = stg2[2];
  end

  // R1: a zero input delay restarts the pixel count on the edge itself
  a_r1_zero_delay: assert property (@(posedge clk) disable iff (!rstN)
    (hsRise && cfgHsInDly == '0) |-> pixStrobe);
endmodule

// File: rtl/sync_dp.sv
module sync_dp
  import syncgen_pkg::*;
#(
  parameter int PIX_W  = 13,
  parameter int HLEN_W = 10,
  parameter int LINE_W = 11,
  parameter int MEAS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  syncStrb_t         strb,
  input  logic [PIX_W-1:0]  cfgHDly,
  input  logic [HLEN_W-1:0] cfgHLen,
  input  logic [LINE_W-1:0] cfgVDly,
  input  logic [LINE_W-1:0] cfgVLen,
  input  logic [LINE_W-1:0] cfgVDly2,
  input  logic [LINE_W-1:0] cfgVLen2,
  input  logic              cfgHPol,
  input  logic              cfgVPol,
  output logic              hsOut,
  output logic              vsOut,
  output logic [MEAS_W-1:0] hsHighClks,
  output logic [MEAS_W-1:0] vsHighLines
);
  localparam logic [PIX_W-1:0]  PIX_MAX  = '1;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;
  localparam logic [MEAS_W-1:0] MEAS_MAX = '1;

  logic [PIX_W-1:0]  pixCnt;
  logic [LINE_W-1:0] lineCnt;
  logic [HLEN_W-1:0] hRem;
  logic [LINE_W-1:0] vRem;
  logic [LINE_W-1:0] vDlySel, vLenSel;
  logic [MEAS_W-1:0] hsRun, vsRun;
  logic              lineTick, hAct, vAct;

  // raster counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCnt  <= '0;
      lineCnt <= '0;
    end else begin
      if (strb.pixRst)            pixCnt <= '0;
      else if (pixCnt != PIX_MAX) pixCnt <= pixCnt + PIX_W'(1);
      if (strb.lineRst)                           lineCnt <= '0;
      else if (strb.pixRst && lineCnt != LINE_MAX) lineCnt <= lineCnt + LINE_W'(1);
    end
  end

  assign lineTick = (pixCnt == '0);
  assign vDlySel  = strb.field2 ? cfgVDly2 : cfgVDly;
  assign vLenSel  = strb.field2 ? cfgVLen2 : cfgVLen;

  // pulse shapers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hRem <= '0;
      vRem <= '0;
    end else begin
      if (pixCnt == cfgHDly && cfgHLen != '0) hRem <= cfgHLen;
      else if (hRem != '0)                    hRem <= hRem - HLEN_W'(1);
      if (lineTick) begin
        if (lineCnt == vDlySel && vLenSel != '0) vRem <= vLenSel;
        else if (vRem != '0)                     vRem <= vRem - LINE_W'(1);
      end
    end
  end

  assign hAct  = (hRem != '0);
  assign vAct  = (vRem != '0);
  assign hsOut = cfgHPol ? hAct : ~hAct;
  assign vsOut = cfgVPol ? vAct : ~vAct;

  // input high-time measurement
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsRun       <= '0;
      vsRun       <= '0;
      hsHighClks  <= '0;
      vsHighLines <= '0;
    end else begin
      if (strb.hsLvl) begin
        if (hsRun != MEAS_MAX) hsRun <= hsRun + MEAS_W'(1);
      end else begin
        hsRun <= '0;
      end
      if (strb.hsFall) hsHighClks <= hsRun;
      if (strb.vsLvl) begin
        if (strb.hsRise && vsRun != MEAS_MAX) vsRun <= vsRun + MEAS_W'(1);
      end else begin
        vsRun <= '0;
      end
      if (strb.vsFall) vsHighLines <= vsRun;
    end
  end

  // R1: a restart strobe zeroes the pixel counter
  a_r1_pix_restart: assert property (@(posedge clk) disable iff (!rstN)
    strb.pixRst |=> (pixCnt == '0));
  // R2: the horizontal pulse only starts from a match on its start pixel
  a_r2_hs_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hAct) |-> ($past(pixCnt) == $past(cfgHDly)));
  // R3: the vertical clear takes precedence over the line advance
  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    strb.lineRst |=> (lineCnt == '0));
  // R4: the vertical output changes only on a line tick
  a_r4_vs_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!lineTick) |=> $stable(vAct) || $fell(vAct) == 1'b0 && $stable(vRem));
  // R8: the horizontal measurement moves only on a horizontal fall
  a_r8_meas_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.hsFall) |=> $stable(hsHighClks));
  // R10: a saturated run stays saturated while the input is high
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (hsRun == MEAS_MAX && strb.hsLvl) |=> (hsRun == MEAS_MAX));
endmodule

// File: rtl/sync_out_gen.sv
module sync_out_gen #(
  parameter int PIX_W  = 13,
  parameter int HLEN_W = 10,
  parameter int LINE_W = 11,
  parameter int DLY_W  = 13,
  parameter int MEAS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsIn,
  input  logic              vsIn,
  input  logic              fieldIn,
  input  logic [DLY_W-1:0]  cfgHsInDly,
  input  logic [DLY_W-1:0]  cfgVsInDly,
  input  logic [PIX_W-1:0]  cfgHDly,
  input  logic [HLEN_W-1:0] cfgHLen,
  input  logic [LINE_W-1:0] cfgVDly,
  input  logic [LINE_W-1:0] cfgVLen,
  input  logic [LINE_W-1:0] cfgVDly2,
  input  logic [LINE_W-1:0] cfgVLen2,
  input  logic              cfgHPol,
  input  logic              cfgVPol,
  output logic              hsOut,
  output logic              vsOut,
  output logic [MEAS_W-1:0] hsHighClks,
  output logic [MEAS_W-1:0] vsHighLines
);
  syncgen_pkg::syncStrb_t strb;

  sync_ctrl #(.DLY_W(DLY_W)) uCtrl (
    .clk(clk), .rstN(rstN), .hsIn(hsIn), .vsIn(vsIn), .fieldIn(fieldIn),
    .cfgHsInDly(cfgHsInDly), .cfgVsInDly(cfgVsInDly), .strb(strb));

  sync_dp #(.PIX_W(PIX_W), .HLEN_W(HLEN_W), .LINE_W(LINE_W), .MEAS_W(MEAS_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgHDly(cfgHDly), .cfgHLen(cfgHLen),
    .cfgVDly(cfgVDly), .cfgVLen(cfgVLen), .cfgVDly2(cfgVDly2), .cfgVLen2(cfgVLen2),
    .cfgHPol(cfgHPol), .cfgVPol(cfgVPol),
    .hsOut(hsOut), .vsOut(vsOut), .hsHighClks(hsHighClks), .vsHighLines(vsHighLines));
endmodule

// File: tb/sync_out_gen_test.sv
module sync_out_gen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hsIn = 1'b0, vsIn = 1'b0, fieldIn = 1'b0;
  logic [12:0] cfgHsInDly = 13'd3, cfgVsInDly = 13'd3, cfgHDly = 13'd4;
  logic [9:0]  cfgHLen = 10'd6;
  logic [10:0] cfgVDly = 11'd2, cfgVLen = 11'd3, cfgVDly2 = 11'd1, cfgVLen2 = 11'd1;
  logic        cfgHPol = 1'b1, cfgVPol = 1'b1;
  logic        hsOut, vsOut;
  logic [15:0] hsHighClks, vsHighLines;

  always #10 clk = ~clk;  // 50 MHz

  sync_out_gen uut (
    .clk(clk), .rstN(rstN), .hsIn(hsIn), .vsIn(vsIn), .fieldIn(fieldIn),
    .cfgHsInDly(cfgHsInDly), .cfgVsInDly(cfgVsInDly), .cfgHDly(cfgHDly), .cfgHLen(cfgHLen),
    .cfgVDly(cfgVDly), .cfgVLen(cfgVLen), .cfgVDly2(cfgVDly2), .cfgVLen2(cfgVLen2),
    .cfgHPol(cfgHPol), .cfgVPol(cfgVPol),
    .hsOut(hsOut), .vsOut(vsOut), .hsHighClks(hsHighClks), .vsHighLines(vsHighLines));

  typedef struct {
    int    cyc;
    int    kind;  // 0 hsOut, 1 vsOut, 2 hsHighClks, 3 vsHighLines
    int    exp;
    string tag;
  } item_t;

  item_t q[$];
  item_t it;
  int    cyc = 0;
  int    nChecks = 0;
  int    nFail = 0;
  int    got;

  task automatic chk(string tag, int actual, int expected);
    nChecks++;
    if (actual != expected) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, actual, expected, cyc);
    end
  endtask

  // monitor: sample 5 ns after each rising edge and pop due items
  always @(posedge clk) begin
    cyc++;
    #5;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      it = q.pop_front();
      case (it.kind)
        0: got = int'(hsOut);
        1: got = int'(vsOut);
        2: got = int'(hsHighClks);
        default: got = int'(vsHighLines);
      endcase
      if (it.cyc < cyc) chk({it.tag, " missed"}, -1, it.exp);
      else              chk(it.tag, got, it.exp);
    end
  end

  function automatic void push(int c, int k, int e, string t);
    item_t n;
    n.cyc = c; n.kind = k; n.exp = e; n.tag = t;
    q.push_back(n);
  endfunction

  // drive one 40-clock line; hsIn is high for 5 clocks
  task automatic runLine(int n, int vd, int vl, int vhl, int hd, int hl, int dly,
                         bit hp, bit vp, bit last, string hTag, string vTag);
    int  c0, s;
    bit  prevA, curA;
    @(negedge clk);
    c0 = cyc;
    hsIn = 1'b1;
    if (n == 0)   vsIn = 1'b1;
    if (n == vhl) vsIn = 1'b0;
    prevA = (n > 0) && (vl > 0) && (n - 1 >= vd) && (n - 1 < vd + vl);
    curA  = (vl > 0) && (n >= vd) && (n < vd + vl);
    push(c0 + 3 + dly, 1, prevA ? int'(vp) : int'(!vp), vTag);
    push(c0 + 4 + dly, 1, curA  ? int'(vp) : int'(!vp), vTag);
    s = c0 + 4 + dly + hd;
    push(s - 1, 0, int'(!hp), hTag);
    if (hl == 0) begin
      push(s, 0, int'(!hp), hTag);
      push(s + 1, 0, int'(!hp), hTag);
    end else begin
      push(s, 0, int'(hp), hTag);
      push(s + hl - 1, 0, int'(hp), hTag);
      push(s + hl, 0, int'(!hp), hTag);
    end
    if (last) begin
      push(c0 + 30, 2, 5, "R8 horizontal high time");
      push(c0 + 31, 3, vhl, "R9 vertical high lines");
    end
    repeat (5) @(negedge clk);
    hsIn = 1'b0;
    repeat (34) @(negedge clk);
  endtask

  task automatic runFrame(bit fld, int vd, int vl, int hd, int hl, int dly,
                          bit hp, bit vp, string hTag, string vTag);
    fieldIn = fld;
    repeat (6) @(negedge clk);
    for (int n = 0; n < 6; n++)
      runLine(n, vd, vl, 2, hd, hl, dly, hp, vp, n == 5, hTag, vTag);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6: reset state, active-high polarity -> outputs low
    chk("R6 reset hsOut", int'(hsOut), 0);
    chk("R6 reset vsOut", int'(vsOut), 0);
    chk("R6 reset hsHighClks", int'(hsHighClks), 0);
    chk("R6 reset vsHighLines", int'(vsHighLines), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2 R3 R4: first field, delays of 3, coincident vertical and horizontal edges
    runFrame(1'b0, 2, 3, 4, 6, 3, 1'b1, 1'b1, "R1,R2 hs window", "R3,R4 vs window");
    // R5: second field uses the alternate pair (1, 1)
    runFrame(1'b1, 1, 1, 4, 6, 3, 1'b1, 1'b1, "R2 hs window field2", "R5 vs second field");
    // R6: both outputs active low
    cfgHPol = 1'b0; cfgVPol = 1'b0;
    runFrame(1'b0, 2, 3, 4, 6, 3, 1'b0, 1'b0, "R6 hs active low", "R6 vs active low");
    // R7: zero lengths keep both outputs inactive
    cfgHPol = 1'b1; cfgVPol = 1'b1;
    cfgHLen = 10'd0; cfgVLen = 11'd0;
    runFrame(1'b0, 2, 0, 4, 0, 3, 1'b1, 1'b1, "R7 hs zero length", "R7 vs zero length");
    // R1 R4: zero input delays, new widths
    cfgHLen = 10'd3; cfgVLen = 11'd2;
    cfgHsInDly = 13'd0; cfgVsInDly = 13'd0;
    runFrame(1'b0, 2, 2, 4, 3, 0, 1'b1, 1'b1, "R1 zero input delay hs", "R4 zero input delay vs");

    // R10: horizontal input held high past the counter range
    @(negedge clk);
    hsIn = 1'b1;
    repeat (70000) @(negedge clk);
    hsIn = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10 saturated hsHighClks", int'(hsHighClks), 65535);

    repeat (5) @(negedge clk);
    chk("scoreboard drained", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule